// File: doc/BRIEF.md
# Flash Page Program-Verify Sequencer

This block writes one page of data into a flash-style array. A requester hands over a page-aligned start address, a byte count from 1 to 128 and the data in a single valid/ready transfer. The controller fills every position past the count with FFh. It reads the whole page back to confirm that the page is blank. It then loops over three steps: it loads the page latch byte by byte, it applies a program pulse, and it verifies the page one longword at a time. After each verify it rebuilds the data to program from the bits that are still unprogrammed.

Each program pulse stays on until the array reports that the pulse is complete. A watchdog counted in clock cycles cuts the pulse short if it runs too long. Before each verify read the controller writes FFh to the address it is about to read. The loop ends with done when every bit has programmed, and with fail when the configured number of pulses is used up. The block reports its outcome as one of five one-cycle status pulses, and it holds busy high while it works.

Top module: `page_prog_seq`

## Requirements
- R1: The byte at page position i (bits 8i+7..8i of `req_data`) is programmed only when i < `req_count`. Every other position is loaded into the latch as FFh, whatever the requester supplied there, and it stays erased.
- R2: A request whose address has any of bits 6..0 set raises `align_error` in the cycle after acceptance. No memory strobe of any kind is issued for it. Offsets 00h and 80h within a 256-byte block are both accepted.
- R3: Before every pulse, exactly 128 latch writes are issued on consecutive cycles. Their addresses are the page base plus 0, 1, ..., 127 in ascending order.
- R4: Before the first pulse, the controller reads all 32 longwords of the page. If any byte is not FFh, it raises `not_erased_error` and issues no pulse.
- R5: `mem_prog_en` stays high from the first cycle of a pulse until the cycle in which `mem_prog_done` is seen. That completed pulse counts as one attempt.
- R6: If `mem_prog_en` has been high for WDOG_CYCLES cycles without `mem_prog_done`, `timeout` is raised, `mem_prog_en` is low from the next cycle, and the request ends. If `mem_prog_done` arrives in that last allowed cycle, the pulse counts as completed.
- R7: After each pulse, the 32 words are visited in ascending order. Each word gets a write of FFh (`mem_dummy_we`) to its byte address, followed in the next cycle by a read (`mem_rd_en`) of the same address. Read data is taken one cycle after the read strobe, with byte 4w+k in bits 8k+7..8k.
- R8: After a verify, each bit to program next is target OR NOT read. A byte that is fully programmed is therefore loaded as FFh on later passes, and bytes that are still short keep their target value.
- R9: `done` is raised when a verify pass leaves every bit to program at 1.
- R10: `fail` is raised once MAX_TRIES pulses have completed and bits still remain to program.
- R11: After reset `busy` is 0, `req_ready` is 1 and every status output is 0. Each status output is a one-cycle pulse, at most one is high in any cycle, and `busy` is high from acceptance until the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request taken |
| req_addr | input | ADDR_W | Page start byte address |
| req_count | input | CNT_W | Number of valid bytes, 1..PAGE_BYTES |
| req_data | input | PAGE_BYTES*8 | Page data, byte i at bits 8i+7..8i |
| busy | output | 1 | Request in progress |
| done | output | 1 | Page verified (pulse) |
| fail | output | 1 | Retry limit reached (pulse) |
| align_error | output | 1 | Start address misaligned (pulse) |
| not_erased_error | output | 1 | Page not blank (pulse) |
| timeout | output | 1 | Program pulse aborted by watchdog (pulse) |
| mem_addr | output | ADDR_W | Byte address for latch write, dummy write or read |
| mem_wdata | output | 8 | Latch byte, or FFh for the dummy write |
| mem_latch_we | output | 1 | Write one byte into the page latch |
| mem_dummy_we | output | 1 | Dummy write ahead of a verify read |
| mem_rd_en | output | 1 | Longword read strobe |
| mem_rd_data | input | 32 | Longword read data, valid one cycle after the strobe |
| mem_prog_en | output | 1 | Program pulse enable |
| mem_prog_done | input | 1 | Array reports the pulse complete |

## Verification
The two events that can fall in one cycle are the array's pulse completion and the watchdog expiry. Both are judged in the last cycle that the pulse is allowed. The bench programs its array model to answer after exactly WDOG_CYCLES cycles of enable, and expects a completed pulse followed by `done`. It then sets the answer one cycle later and expects `timeout`, an enable that was high for exactly WDOG_CYCLES cycles, and an untouched array.

// File: rtl/page_prog_pkg.sv
// Shared types for the page program-verify sequencer.
// Assumes nothing beyond a single clock domain.
package page_prog_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_BLANK_RD,
        ST_BLANK_CHK,
        ST_LOAD,
        ST_PULSE,
        ST_DUMMY,
        ST_VRD,
        ST_VCAP,
        ST_EVAL
    } seq_state_t;

endpackage

// File: rtl/page_pad.sv
// Pads a requested page: positions at or beyond the byte count become FFh.
// Assumes the count is in 1..PAGE_BYTES; purely combinational.
module page_pad #(
    parameter int PAGE_BYTES = 128,
    parameter int CNT_W      = 8
) (
    input  logic [PAGE_BYTES*8-1:0] raw,
    input  logic [CNT_W-1:0]        count,
    output logic [PAGE_BYTES*8-1:0] padded
);
    // One selector per byte position.
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_byte
        assign padded[g*8 +: 8] = (CNT_W'(g) < count) ? raw[g*8 +: 8] : 8'hFF;
    end
endmodule

// File: rtl/pulse_watchdog.sv
// Counts consecutive cycles of an active program pulse and flags the last
// allowed cycle. Assumes LIMIT >= 1; the counter clears whenever run drops.
module pulse_watchdog #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    // Cycle counter for the current pulse, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt != CW'(LIMIT - 1)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Flag the final cycle in which the pulse may still be held.
    assign expired = run && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/verify_merge.sv
// Folds one verified longword into the reprogram image: a bit becomes 1 once
// it reads 0 and otherwise keeps its target value. Also reports whether the
// current image is all ones. Assumes target bits of 1 always read back as 1.
module verify_merge #(
    parameter int PAGE_BYTES = 128,
    parameter int WIDX_W     = 5
) (
    input  logic [PAGE_BYTES*8-1:0] target,
    input  logic [PAGE_BYTES*8-1:0] reprog,
    input  logic [WIDX_W-1:0]       widx,
    input  logic [31:0]             rd_word,
    output logic [PAGE_BYTES*8-1:0] merged,
    output logic                    all_set
);
    localparam int WORDS = PAGE_BYTES / 4;

    // Replace only the word just read.
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        assign merged[w*32 +: 32] = (widx == WIDX_W'(w))
                                  ? (target[w*32 +: 32] | ~rd_word)
                                  : reprog[w*32 +: 32];
    end

    // Page finished when nothing remains to program.
    assign all_set = &reprog;
endmodule

// File: rtl/page_prog_seq.sv
// Page program-verify sequencer. Accepts one aligned page, checks it is blank,
// then loops latch-load / program pulse / dummy-write + longword verify until
// every bit is programmed or MAX_TRIES pulses are used. Assumes the memory
// returns read data one cycle after mem_rd_en and raises mem_prog_done while
// mem_prog_en is high.
module page_prog_seq
    import page_prog_pkg::*;
#(
    parameter int PAGE_BYTES  = 128,
    parameter int ADDR_W      = 16,
    parameter int MAX_TRIES   = 8,
    parameter int WDOG_CYCLES = 264000,
    parameter int CNT_W       = $clog2(PAGE_BYTES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [CNT_W-1:0]        req_count,
    input  logic [PAGE_BYTES*8-1:0] req_data,
    output logic                    busy,
    output logic                    done,
    output logic                    fail,
    output logic                    align_error,
    output logic                    not_erased_error,
    output logic                    timeout,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [7:0]              mem_wdata,
    output logic                    mem_latch_we,
    output logic                    mem_dummy_we,
    output logic                    mem_rd_en,
    input  logic [31:0]             mem_rd_data,
    output logic                    mem_prog_en,
    input  logic                    mem_prog_done
);
    localparam int IDX_W  = $clog2(PAGE_BYTES);
    localparam int WORDS  = PAGE_BYTES / 4;
    localparam int WIDX_W = $clog2(WORDS);
    localparam int TRY_W  = $clog2(MAX_TRIES + 1);
    localparam int HI_W   = ADDR_W - IDX_W;

    seq_state_t                 state;
    logic [HI_W-1:0]            base_hi;
    logic [PAGE_BYTES*8-1:0]    target;
    logic [PAGE_BYTES*8-1:0]    reprog;
    logic [PAGE_BYTES*8-1:0]    padded;
    logic [PAGE_BYTES*8-1:0]    merged;
    logic                       all_set;
    logic [IDX_W-1:0]           idx;
    logic [WIDX_W-1:0]          widx;
    logic [TRY_W-1:0]           tries;
    logic                       blank_bad;
    logic                       wd_expired;
    logic                       done_q, fail_q, align_q, nerase_q, tmo_q;
    logic                       bad_now;

    page_pad #(.PAGE_BYTES(PAGE_BYTES), .CNT_W(CNT_W)) u_pad (
        .raw    (req_data),
        .count  (req_count),
        .padded (padded)
    );

    pulse_watchdog #(.LIMIT(WDOG_CYCLES)) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (mem_prog_en),
        .expired (wd_expired)
    );

    verify_merge #(.PAGE_BYTES(PAGE_BYTES), .WIDX_W(WIDX_W)) u_merge (
        .target  (target),
        .reprog  (reprog),
        .widx    (widx),
        .rd_word (mem_rd_data),
        .merged  (merged),
        .all_set (all_set)
    );

    // Blank-check result including the word arriving this cycle.
    assign bad_now = blank_bad || (mem_rd_data != 32'hFFFF_FFFF);

    // Sequencer state, page images, counters and one-cycle status pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            base_hi   <= '0;
            target    <= '1;
            reprog    <= '1;
            idx       <= '0;
            widx      <= '0;
            tries     <= '0;
            blank_bad <= 1'b0;
            done_q    <= 1'b0;
            fail_q    <= 1'b0;
            align_q   <= 1'b0;
            nerase_q  <= 1'b0;
            tmo_q     <= 1'b0;
        end else begin
            done_q   <= 1'b0;
            fail_q   <= 1'b0;
            align_q  <= 1'b0;
            nerase_q <= 1'b0;
            tmo_q    <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (req_addr[IDX_W-1:0] != '0) begin
                            align_q <= 1'b1;
                        end else begin
                            base_hi   <= req_addr[ADDR_W-1:IDX_W];
                            target    <= padded;
                            widx      <= '0;
                            blank_bad <= 1'b0;
                            state     <= ST_BLANK_RD;
                        end
                    end
                end
                ST_BLANK_RD: state <= ST_BLANK_CHK;
                ST_BLANK_CHK: begin
                    blank_bad <= bad_now;
                    if (widx == WIDX_W'(WORDS - 1)) begin
                        if (bad_now) begin
                            nerase_q <= 1'b1;
                            state    <= ST_IDLE;
                        end else begin
                            reprog <= target;
                            idx    <= '0;
                            tries  <= '0;
                            state  <= ST_LOAD;
                        end
                    end else begin
                        widx  <= widx + 1'b1;
                        state <= ST_BLANK_RD;
                    end
                end
                ST_LOAD: begin
                    idx <= idx + 1'b1;
                    if (idx == IDX_W'(PAGE_BYTES - 1)) state <= ST_PULSE;
                end
                ST_PULSE: begin
                    if (mem_prog_done) begin
                        tries <= tries + 1'b1;
                        widx  <= '0;
                        state <= ST_DUMMY;
                    end else if (wd_expired) begin
                        tmo_q <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                ST_DUMMY: state <= ST_VRD;
                ST_VRD:   state <= ST_VCAP;
                ST_VCAP: begin
                    reprog <= merged;
                    if (widx == WIDX_W'(WORDS - 1)) begin
                        state <= ST_EVAL;
                    end else begin
                        widx  <= widx + 1'b1;
                        state <= ST_DUMMY;
                    end
                end
                ST_EVAL: begin
                    if (all_set) begin
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else if (tries == TRY_W'(MAX_TRIES)) begin
                        fail_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else begin
                        idx   <= '0;
                        state <= ST_LOAD;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Memory-side strobes and address decoded from the state.
    always_comb begin
        mem_latch_we = (state == ST_LOAD);
        mem_prog_en  = (state == ST_PULSE);
        mem_dummy_we = (state == ST_DUMMY);
        mem_rd_en    = (state == ST_BLANK_RD) || (state == ST_VRD);
        mem_wdata    = (state == ST_LOAD) ? reprog[idx*8 +: 8] : 8'hFF;
        mem_addr     = (state == ST_LOAD) ? {base_hi, idx}
                                          : {base_hi, widx, 2'b00};
    end

    // Requester-side handshake and status outputs.
    assign req_ready        = (state == ST_IDLE);
    assign busy             = (state != ST_IDLE);
    assign done             = done_q;
    assign fail             = fail_q;
    assign align_error      = align_q;
    assign not_erased_error = nerase_q;
    assign timeout          = tmo_q;
endmodule

// File: rtl/page_prog_seq_chk.sv
// Protocol checker for page_prog_seq, attached by bind. Observes ports only.
module page_prog_seq_chk #(
    parameter int ADDR_W      = 16,
    parameter int WDOG_CYCLES = 264000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              busy,
    input logic              done,
    input logic              fail,
    input logic              align_error,
    input logic              not_erased_error,
    input logic              timeout,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_wdata,
    input logic              mem_latch_we,
    input logic              mem_dummy_we,
    input logic              mem_rd_en,
    input logic              mem_prog_en
);
    localparam int CW = $clog2(WDOG_CYCLES + 2);

    logic [CW-1:0] pe_run;
    logic          seen_pulse;

    // Count earlier consecutive cycles of program enable.
    always_ff @(posedge clk) begin
        if (!rst_n)                      pe_run <= '0;
        else if (!mem_prog_en)           pe_run <= '0;
        else if (pe_run != '1)           pe_run <= pe_run + 1'b1;
    end

    // Remember whether the current request has pulsed yet.
    always_ff @(posedge clk) begin
        if (!rst_n)                      seen_pulse <= 1'b0;
        else if (req_valid && req_ready) seen_pulse <= 1'b0;
        else if (mem_prog_en)            seen_pulse <= 1'b1;
    end

    assert_latch_consecutive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_latch_we && $past(mem_latch_we)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

    assert_no_pulse_when_dirty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        not_erased_error |-> !seen_pulse);

    assert_pulse_within_wdog_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_prog_en |-> (pe_run < CW'(WDOG_CYCLES)));

    assert_timeout_drops_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (!mem_prog_en && $past(mem_prog_en)));

    assert_dummy_before_verify_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && seen_pulse) |-> ($past(mem_dummy_we) && $past(mem_addr) == mem_addr));

    assert_dummy_is_ff_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dummy_we |-> (mem_wdata == 8'hFF));

    assert_outcome_after_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fail) |-> seen_pulse);

    assert_align_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        align_error |-> ($past(req_valid) && !busy));

    assert_single_status_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, fail, align_error, not_erased_error, timeout}));

    assert_status_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fail || timeout || not_erased_error) |=> !(done || fail || timeout || not_erased_error));
endmodule

bind page_prog_seq page_prog_seq_chk #(
    .ADDR_W      (ADDR_W),
    .WDOG_CYCLES (WDOG_CYCLES)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .req_valid        (req_valid),
    .req_ready        (req_ready),
    .busy             (busy),
    .done             (done),
    .fail             (fail),
    .align_error      (align_error),
    .not_erased_error (not_erased_error),
    .timeout          (timeout),
    .mem_addr         (mem_addr),
    .mem_wdata        (mem_wdata),
    .mem_latch_we     (mem_latch_we),
    .mem_dummy_we     (mem_dummy_we),
    .mem_rd_en        (mem_rd_en),
    .mem_prog_en      (mem_prog_en)
);

// File: tb/tb_page_prog_seq.sv
// Bench for page_prog_seq: behavioural array model with per-byte pulse needs,
// directed corner cases plus seeded random pages.
module tb_page_prog_seq;
    localparam int PB    = 128;
    localparam int AW    = 16;
    localparam int MAXT  = 4;
    localparam int WD    = 20;
    localparam int MSIZE = 1024;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_count = 8'd0;
    logic [PB*8-1:0] req_data = '0;
    logic          busy, done, fail, align_error, not_erased_error, timeout;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic          mem_latch_we, mem_dummy_we, mem_rd_en, mem_prog_en;
    logic [31:0]   mem_rd_data;
    logic          mem_prog_done;

    page_prog_seq #(.PAGE_BYTES(PB), .ADDR_W(AW), .MAX_TRIES(MAXT), .WDOG_CYCLES(WD)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_count(req_count), .req_data(req_data),
        .busy(busy), .done(done), .fail(fail), .align_error(align_error),
        .not_erased_error(not_erased_error), .timeout(timeout),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_latch_we(mem_latch_we),
        .mem_dummy_we(mem_dummy_we), .mem_rd_en(mem_rd_en), .mem_rd_data(mem_rd_data),
        .mem_prog_en(mem_prog_en), .mem_prog_done(mem_prog_done)
    );

    always #10 clk = ~clk;

    // ---------------- array model ----------------
    logic [7:0] arr   [0:MSIZE-1];
    logic [7:0] latch [0:PB-1];
    int         need  [0:PB-1];
    logic [7:0] exp_target [0:PB-1];
    int         hits  [0:PB-1];
    logic       prog_ok [0:PB-1];
    logic [9:0] mbase;
    int pd_cfg = 3;
    int pc, seq, pulses, order_err, latch_mis, dummy_miss, strobes, pe_cycles;
    logic       dummy_prev;
    logic [AW-1:0] dummy_addr;
    logic       model_erase = 1'b0, model_poke = 1'b0;
    logic [9:0] poke_addr = '0;
    logic [7:0] poke_val = '0;

    assign mem_prog_done = mem_prog_en && (pc == pd_cfg - 1);

    always @(posedge clk) begin
        if (model_erase) for (int i = 0; i < MSIZE; i++) arr[i] <= 8'hFF;
        if (model_poke) arr[poke_addr] <= poke_val;
        if (req_valid && req_ready) begin
            mbase <= req_addr[9:0];
            pc <= 0; seq <= 0; pulses <= 0; order_err <= 0; latch_mis <= 0;
            dummy_miss <= 0; strobes <= 0; pe_cycles <= 0; dummy_prev <= 1'b0;
            for (int i = 0; i < PB; i++) begin hits[i] <= 0; prog_ok[i] <= 1'b0; end
        end else begin
            if (mem_latch_we || mem_dummy_we || mem_rd_en || mem_prog_en) strobes <= strobes + 1;
            if (mem_latch_we) begin
                latch[mem_addr[6:0]] <= mem_wdata;
                if (int'(mem_addr[6:0]) != seq || mem_addr[9:7] != mbase[9:7]) order_err <= order_err + 1;
                seq <= seq + 1;
            end
            pc <= mem_prog_en ? pc + 1 : 0;
            if (mem_prog_en) pe_cycles <= pe_cycles + 1;
            if (mem_prog_en && pc == 0) begin
                pulses <= pulses + 1;
                if (seq != PB) order_err <= order_err + 1;
                seq <= 0;
                for (int i = 0; i < PB; i++)
                    if (latch[i] != (prog_ok[i] ? 8'hFF : exp_target[i])) latch_mis <= latch_mis + 1;
            end
            if (mem_prog_en && mem_prog_done) begin
                for (int i = 0; i < PB; i++) if (latch[i] != 8'hFF) begin
                    hits[i] <= hits[i] + 1;
                    if (hits[i] + 1 >= need[i]) begin
                        arr[mbase + 10'(i)] <= arr[mbase + 10'(i)] & latch[i];
                        prog_ok[i] <= 1'b1;
                    end
                end
            end
            dummy_prev <= mem_dummy_we;
            dummy_addr <= mem_addr;
            if (mem_rd_en) begin
                mem_rd_data <= {arr[mem_addr[9:0] + 10'd3], arr[mem_addr[9:0] + 10'd2],
                                arr[mem_addr[9:0] + 10'd1], arr[mem_addr[9:0]]};
                if (pulses > 0 && (!dummy_prev || dummy_addr != mem_addr)) dummy_miss <= dummy_miss + 1;
            end
        end
    end

    // ---------------- checking ----------------
    int total = 0, failed = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic logic [7:0] pad_byte(input logic [PB*8-1:0] d, input int cnt, input int i);
        return (i < cnt) ? d[i*8 +: 8] : 8'hFF;
    endfunction

    task automatic erase_all();
        @(negedge clk); model_erase = 1'b1;
        @(negedge clk); model_erase = 1'b0;
    endtask

    task automatic poke(input logic [9:0] a, input logic [7:0] v);
        @(negedge clk); model_poke = 1'b1; poke_addr = a; poke_val = v;
        @(negedge clk); model_poke = 1'b0;
    endtask

    // code: 1 done, 2 fail, 3 align, 4 not erased, 5 timeout, 0 none
    task automatic run_req(input logic [AW-1:0] a, input int cnt, input logic [PB*8-1:0] d,
                           output int code, output bit busy_seen);
        for (int i = 0; i < PB; i++) exp_target[i] = pad_byte(d, cnt, i);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_count = 8'(cnt); req_data = d;
        @(negedge clk);
        req_valid = 1'b0; req_data = '1;
        code = 0; busy_seen = 1'b0;
        for (int k = 0; k < 40000 && code == 0; k++) begin
            if (busy) busy_seen = 1'b1;
            if (done) code = 1;
            else if (fail) code = 2;
            else if (align_error) code = 3;
            else if (not_erased_error) code = 4;
            else if (timeout) code = 5;
            else @(negedge clk);
        end
    endtask

    // Full request with expected outcome computed from the needs table.
    task automatic prog_and_check(input logic [AW-1:0] a, input int cnt, input logic [PB*8-1:0] d,
                                  input string tag);
        int code, mx, exp_code, exp_p, bad;
        bit bs;
        logic [7:0] eb;
        mx = 0;
        for (int i = 0; i < PB; i++)
            if (pad_byte(d, cnt, i) != 8'hFF && need[i] > mx) mx = need[i];
        if (mx == 0) mx = 1;
        exp_code = (mx <= MAXT) ? 1 : 2;
        exp_p    = (mx <= MAXT) ? mx : MAXT;
        run_req(a, cnt, d, code, bs);
        check(code == exp_code, {tag, " R9 R10 outcome"}, code, exp_code);
        check(pulses == exp_p, {tag, " R5 R8 pulse count"}, pulses, exp_p);
        bad = 0;
        for (int i = 0; i < PB; i++) begin
            eb = (pad_byte(d, cnt, i) != 8'hFF && need[i] <= exp_p) ? pad_byte(d, cnt, i) : 8'hFF;
            if (arr[a[9:0] + 10'(i)] != eb) bad++;
        end
        check(bad == 0, {tag, " R1 R8 array contents"}, bad, 0);
        check(order_err == 0, {tag, " R3 latch order"}, order_err, 0);
        check(latch_mis == 0, {tag, " R8 reprogram latch data"}, latch_mis, 0);
        check(dummy_miss == 0, {tag, " R7 dummy write before read"}, dummy_miss, 0);
        check(bs, {tag, " R11 busy during request"}, bs, 1);
    endtask

    // Watchdog on the whole run.
    initial begin
        repeat (200000) @(posedge clk);
        total++; failed++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        int code;
        bit bs;
        logic [PB*8-1:0] d;
        void'($urandom(32'd2024));
        for (int i = 0; i < PB; i++) need[i] = 1;
        repeat (3) @(negedge clk);
        // R11: reset state
        check(!busy && req_ready, "R11 reset busy/ready", {busy, req_ready}, 2'b01);
        check({done, fail, align_error, not_erased_error, timeout} == 5'b0, "R11 reset status",
              {done, fail, align_error, not_erased_error, timeout}, 0);
        rst_n = 1'b1;
        erase_all();

        // R2: misaligned address
        run_req(16'h0140, 128, '0, code, bs);
        check(code == 3, "R2 misaligned start", code, 3);
        check(strobes == 0, "R2 no memory strobes", strobes, 0);

        // R9 R3: full page at offset 80h, one pulse each
        for (int i = 0; i < PB; i++) d[i*8 +: 8] = 8'(i * 7 + 1);
        prog_and_check(16'h0080, 128, d, "full page");

        // R4: page not blank
        erase_all();
        poke(10'h125, 8'h5A);
        run_req(16'h0100, 128, '0, code, bs);
        check(code == 4, "R4 not erased", code, 4);
        check(pulses == 0, "R4 no pulse issued", pulses, 0);
        check(arr[10'h125] == 8'h5A, "R4 array untouched", arr[10'h125], 8'h5A);

        // R1: one valid byte, junk beyond count
        erase_all();
        d = '0;
        d[7:0] = 8'h3C;
        prog_and_check(16'h0200, 1, d, "short page R1");

        // R8 R10: one byte never programs within the limit
        erase_all();
        for (int i = 0; i < PB; i++) begin need[i] = (i % 3) + 1; d[i*8 +: 8] = 8'(i); end
        need[77] = MAXT + 1;
        prog_and_check(16'h0000, 128, d, "retry limit R10");
        for (int i = 0; i < PB; i++) need[i] = 1;

        // R6: completion in the last allowed cycle wins
        erase_all();
        pd_cfg = WD;
        prog_and_check(16'h0180, 64, d, "done at wdog edge R6");
        // R6: one cycle late -> timeout
        erase_all();
        pd_cfg = WD + 1;
        run_req(16'h0300, 128, d, code, bs);
        check(code == 5, "R6 timeout status", code, 5);
        check(pe_cycles == WD, "R6 enable length", pe_cycles, WD);
        check(arr[10'h300] == 8'hFF, "R6 array untouched", arr[10'h300], 8'hFF);
        check(!mem_prog_en, "R6 enable cleared", mem_prog_en, 0);
        pd_cfg = 3;

        // Random pages
        for (int t = 0; t < 14; t++) begin
            int cnt, pg;
            erase_all();
            pg  = $urandom_range(0, 7);
            cnt = $urandom_range(1, 128);
            for (int i = 0; i < PB; i++) begin
                d[i*8 +: 8] = 8'($urandom);
                need[i] = $urandom_range(1, 3);
            end
            if ($urandom_range(0, 3) == 0) begin
                int b;
                b = $urandom_range(0, cnt - 1);
                d[b*8 +: 8] = 8'h00;
                need[b] = MAXT + 1;
            end
            prog_and_check(AW'(pg * 128), cnt, d, "random");
        end

        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule